// File: doc/BRIEF.md
# Packed BCD byte arithmetic unit

This unit performs decimal arithmetic on bytes that hold two packed BCD digits. It supports three operations: add with extend, subtract with extend, and negate with extend. The operation is decoded from a 16-bit instruction word. The unit also takes a destination operand, a source operand, and the incoming extend (X) and zero (Z) flags.

Every operation works in two steps. A plain binary add or subtract comes first. A decimal correction of 6 per nibble follows. The correction amounts come from the nibble carry and borrow terms of the first step. The unit reproduces one fixed hardware behaviour bit for bit on every operand pair, including operands that are not valid BCD. The flags that are nominally undefined follow fixed equations, and subtraction can emit results that are not valid BCD.

The datapath is combinational. A registered output stage captures the result and all five flags when a valid strobe arrives. An instruction word that matches none of the three operations raises an error output and leaves the result and flags as they were. The reset input is asserted asynchronously and released synchronously inside the block.

Top module: `bcd_byte_alu`

## Requirements
- R1: Decoding uses bit patterns, with `?` marking a free bit. `1100???10000????` selects add, `1000???10000????` selects subtract, and `0100100000??????` selects negate. The free bits (register and mode fields) do not change the operation.
- R2: Add forms S = dst + src + X, modulo 256. A nibble needs +6 when either of two terms is set for it. The first term is the binary carry out of that nibble's top bit (bit 3 or bit 7) in dst + src + X. The second term is the carry out of the same bit when 0x66 is added to S, where bit 8 of S + 0x66 counts as the high-nibble term. The result is S plus the corrections, modulo 256.
- R3: Subtract forms D = dst − src − X, modulo 256. A nibble gets −6 only when the binary borrow out of bit 3 or bit 7 is set. There is no decimal term, so some results are not valid BCD.
- R4: Negate gives exactly the subtract result and flags with dst taken as 0 and src as the operand. The dst input has no effect on negate.
- R5: C and X always carry the same value. That value is the binary carry or borrow out of bit 7 of the first step, ORed with the carry or borrow out of bit 7 of the correction step.
- R6: For add, V is 1 exactly when bit 7 of S is 0 and bit 7 of the result is 1. For subtract and negate, V is 1 exactly when bit 7 of D is 1 and bit 7 of the result is 0.
- R7: Z becomes 0 when the result is nonzero and otherwise keeps the incoming Z, so it is never set by the unit. N equals bit 7 of the result.
- R8: Outputs change on the first clock edge at which `in_valid` is 1. They hold whenever `in_valid` is 0.
- R9: A valid strobe with an unmatched instruction word sets `err_q` to 1 and leaves the result and flags unchanged. A valid strobe with a matched word clears `err_q`.
- R10: After reset, the result, all five flags and `err_q` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe: capture an operation this cycle |
| insn | input | 16 | Instruction word selecting the operation |
| dst_in | input | 8 | Destination operand (minuend / first addend) |
| src_in | input | 8 | Source operand |
| x_in | input | 1 | Incoming extend flag |
| z_in | input | 1 | Incoming zero flag |
| res_q | output | 8 | Registered result byte |
| x_q | output | 1 | Extend flag |
| n_q | output | 1 | Negative flag |
| z_q | output | 1 | Zero flag |
| v_q | output | 1 | Overflow flag |
| c_q | output | 1 | Carry / borrow flag |
| err_q | output | 1 | Unmatched instruction word on last strobe |

## Verification
The correction and flag terms are internal, but any error in them shows up in the registered result or flags one clock after the strobe. A wrong decimal term shows as an off-by-6 nibble on only a small set of operand pairs. For that reason every add and subtract pair is applied, together with every negate operand under all four X/Z combinations. A fault in the hold or error path shows as a changed output on a cycle with no accepted operation.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2,
    OP_NEG  = 2'd3
  } bcd_op_e;

  typedef struct packed {
    logic x;
    logic n;
    logic z;
    logic v;
    logic c;
  } bcd_flags_t;
endpackage

// File: rtl/bcd_op_decode.sv
module bcd_op_decode
  import bcd_alu_pkg::*;
(
  input  logic [15:0] insn,
  output bcd_op_e     op
);
  logic hit_add;
  logic hit_sub;
  logic hit_neg;

  always_comb begin
    hit_add = (insn[15:12] == 4'b1100) && (insn[8:4] == 5'b10000);
    hit_sub = (insn[15:12] == 4'b1000) && (insn[8:4] == 5'b10000);
    hit_neg = (insn[15:6]  == 10'b0100100000);
    if (hit_add)      op = OP_ADD;
    else if (hit_sub) op = OP_SUB;
    else if (hit_neg) op = OP_NEG;
    else              op = OP_NONE;
  end
endmodule

// File: rtl/bcd_corr_unit.sv
module bcd_corr_unit
  import bcd_alu_pkg::*;
#(
  parameter int NDIG = 2
) (
  input  logic              do_sub,
  input  logic [4*NDIG-1:0] dst,
  input  logic [4*NDIG-1:0] src,
  input  logic              x_in,
  input  logic              z_in,
  output logic [4*NDIG-1:0] res,
  output bcd_flags_t        flg
);
  localparam int W = 4 * NDIG;

  logic [W-1:0] nib_top;
  logic [W-1:0] six_pat;
  logic [W-1:0] x_ext;

  genvar k;
  generate
    for (k = 0; k < NDIG; k++) begin : g_nib
      assign nib_top[4*k+3:4*k] = 4'b1000;
      assign six_pat[4*k+3:4*k] = 4'b0110;
    end
  endgenerate

  assign x_ext = {{(W-1){1'b0}}, x_in};

  // addition path: binary step then +6 per flagged nibble
  logic [W-1:0] sum_b;
  logic [W:0]   sum_six;
  logic [W-1:0] add_bc;
  logic [W-1:0] add_dc;
  logic [W-1:0] add_mask;
  logic [W-1:0] add_corf;
  logic [W-1:0] add_res;

  always_comb begin
    sum_b    = dst + src + x_ext;
    add_bc   = ((dst & src) | (~sum_b & dst) | (~sum_b & src)) & nib_top;
    sum_six  = {1'b0, sum_b} + {1'b0, six_pat};
    add_dc   = (sum_six[W:1] ^ {1'b0, sum_b[W-1:1]}) & nib_top;
    add_mask = add_bc | add_dc;
    add_corf = add_mask - (add_mask >> 2);
    add_res  = sum_b + add_corf;
  end

  // subtraction path: binary step then -6 per borrowing nibble
  logic [W-1:0] dif_b;
  logic [W-1:0] sub_bc;
  logic [W-1:0] sub_corf;
  logic [W-1:0] sub_res;

  always_comb begin
    dif_b    = dst - src - x_ext;
    sub_bc   = ((~dst & src) | (dif_b & ~dst) | (dif_b & src)) & nib_top;
    sub_corf = sub_bc - (sub_bc >> 2);
    sub_res  = dif_b - sub_corf;
  end

  logic carry_out;

  always_comb begin
    if (do_sub) begin
      res       = sub_res;
      carry_out = sub_bc[W-1] | (~dif_b[W-1] & sub_res[W-1]);
      flg.v     = dif_b[W-1] & ~sub_res[W-1];
    end else begin
      res       = add_res;
      carry_out = add_bc[W-1] | (sum_b[W-1] & ~add_res[W-1]);
      flg.v     = ~sum_b[W-1] & add_res[W-1];
    end
    flg.c = carry_out;
    flg.x = carry_out;
    flg.n = res[W-1];
    flg.z = z_in & (res == '0);
  end
endmodule

// File: rtl/bcd_byte_alu.sv
module bcd_byte_alu
  import bcd_alu_pkg::*;
#(
  parameter int NDIG = 2,
  parameter int IW   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [IW-1:0]     insn,
  input  logic [4*NDIG-1:0] dst_in,
  input  logic [4*NDIG-1:0] src_in,
  input  logic              x_in,
  input  logic              z_in,
  output logic [4*NDIG-1:0] res_q,
  output logic              x_q,
  output logic              n_q,
  output logic              z_q,
  output logic              v_q,
  output logic              c_q,
  output logic              err_q
);
  localparam int W = 4 * NDIG;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ok = rst_pipe[1];

  bcd_op_e op;

  bcd_op_decode u_dec (
    .insn (insn[15:0]),
    .op   (op)
  );

  logic         is_sub;
  logic         op_hit;
  logic [W-1:0] dst_eff;
  logic [W-1:0] comb_res;
  bcd_flags_t   comb_flg;

  always_comb begin
    is_sub  = (op == OP_SUB) || (op == OP_NEG);
    op_hit  = (op != OP_NONE);
    dst_eff = (op == OP_NEG) ? '0 : dst_in;
  end

  bcd_corr_unit #(.NDIG(NDIG)) u_core (
    .do_sub (is_sub),
    .dst    (dst_eff),
    .src    (src_in),
    .x_in   (x_in),
    .z_in   (z_in),
    .res    (comb_res),
    .flg    (comb_flg)
  );

  // output stage: next-state logic then registers
  logic         upd_data;
  logic         upd_err;
  logic [W-1:0] res_d;
  bcd_flags_t   flg_d;
  bcd_flags_t   flg_q;
  logic         err_d;

  always_comb begin
    upd_data = in_valid && op_hit;
    upd_err  = in_valid;
    res_d    = comb_res;
    flg_d    = comb_flg;
    err_d    = !op_hit;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      res_q <= '0;
      flg_q <= '0;
    end else if (upd_data) begin
      res_q <= res_d;
      flg_q <= flg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok)      err_q <= 1'b0;
    else if (upd_err) err_q <= err_d;
  end

  assign x_q = flg_q.x;
  assign n_q = flg_q.n;
  assign z_q = flg_q.z;
  assign v_q = flg_q.v;
  assign c_q = flg_q.c;

  AST_X_MATCHES_C: assert property (@(posedge clk) disable iff (!rst_ok)
    x_q == c_q); // R5
  AST_Z_NEVER_SET: assert property (@(posedge clk) disable iff (!rst_ok)
    upd_data |=> (!z_q || $past(z_in))); // R7
  AST_Z_CLEAR_NONZERO: assert property (@(posedge clk) disable iff (!rst_ok)
    upd_data |=> (res_q == '0 || !z_q)); // R7
  AST_BAD_OP_HOLDS: assert property (@(posedge clk) disable iff (!rst_ok)
    (in_valid && !op_hit) |=> (err_q && $stable(res_q) && $stable(flg_q))); // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_ok)
    !in_valid |=> ($stable(res_q) && $stable(flg_q) && $stable(err_q))); // R8
  AST_GOOD_OP_NO_ERR: assert property (@(posedge clk) disable iff (!rst_ok)
    upd_data |=> !err_q); // R9
endmodule

// File: tb/bcd_byte_alu_test.sv
module bcd_byte_alu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] insn = 16'h0000;
  logic [7:0]  dst_in = 8'h00;
  logic [7:0]  src_in = 8'h00;
  logic        x_in = 1'b0;
  logic        z_in = 1'b0;
  logic [7:0]  res_q;
  logic        x_q, n_q, z_q, v_q, c_q, err_q;

  always #2 clk = ~clk; // 250 MHz

  bcd_byte_alu uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
    .dst_in(dst_in), .src_in(src_in), .x_in(x_in), .z_in(z_in),
    .res_q(res_q), .x_q(x_q), .n_q(n_q), .z_q(z_q), .v_q(v_q),
    .c_q(c_q), .err_q(err_q)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  // expected registered state
  int e_res = 0;
  bit e_x = 0, e_n = 0, e_z = 0, e_v = 0, e_c = 0, e_err = 0;

  function automatic int kind_of(input logic [15:0] w);
    if (w ==? 16'b1100???10000????) return 1;
    if (w ==? 16'b1000???10000????) return 2;
    if (w ==? 16'b0100100000??????) return 3;
    return 0;
  endfunction

  // behavioural model, nibble arithmetic on integers
  task automatic model(input int kind, input int d, input int s,
                       input bit xi, input bit zi);
    int full, lo, sb, six, fix, r, carry, ovf;
    if (kind == 3) d = 0;
    if (kind == 1) begin
      full = d + s + xi;
      lo   = (d % 16) + (s % 16) + xi;
      sb   = full % 256;
      fix  = 0;
      if (lo > 15 || (sb % 16) >= 10) fix += 6;
      if (full > 255 || sb + 102 > 255) fix += 96;
      r     = (sb + fix) % 256;
      carry = (full > 255 || sb + fix > 255) ? 1 : 0;
      ovf   = (sb < 128 && r >= 128) ? 1 : 0;
    end else begin
      full = d - s - xi;
      lo   = (d % 16) - (s % 16) - xi;
      sb   = (full + 256) % 256;
      fix  = 0;
      if (lo < 0)   fix += 6;
      if (full < 0) fix += 96;
      r     = (sb - fix + 256) % 256;
      carry = (full < 0 || sb - fix < 0) ? 1 : 0;
      ovf   = (sb >= 128 && r < 128) ? 1 : 0;
    end
    e_res = r;
    e_c = carry[0];
    e_x = carry[0];
    e_v = ovf[0];
    e_n = (r >= 128);
    e_z = zi && (r == 0);
  endtask

  task automatic check(input string tag);
    total++;
    if (res_q != e_res[7:0]) begin
      bad++;
      $display("FAIL %s result: got %02h expected %02h", tag, res_q, e_res[7:0]);
    end
    total++;
    if (c_q != e_c || x_q != e_x) begin
      bad++;
      $display("FAIL R5 carry/extend: got c=%0b x=%0b expected %0b", c_q, x_q, e_c);
    end
    total++;
    if (v_q != e_v) begin
      bad++;
      $display("FAIL R6 overflow: got %0b expected %0b", v_q, e_v);
    end
    total++;
    if (z_q != e_z || n_q != e_n) begin
      bad++;
      $display("FAIL R7 zero/neg: got z=%0b n=%0b expected z=%0b n=%0b", z_q, n_q, e_z, e_n);
    end
    total++;
    if (err_q != e_err) begin
      bad++;
      $display("FAIL R9 err: got %0b expected %0b", err_q, e_err);
    end
  endtask

  task automatic step(input bit vld, input logic [15:0] w, input int d,
                      input int s, input bit xi, input bit zi, input string tag);
    int kind;
    in_valid = vld; insn = w; dst_in = d[7:0]; src_in = s[7:0];
    x_in = xi; z_in = zi;
    kind = kind_of(w);
    if (vld) begin
      e_err = (kind == 0);
      if (kind != 0) model(kind, d, s, xi, zi);
    end
    @(negedge clk);
    check(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 reset");

    // R2 corner: 99 + 01 -> 00 with carry; Z stays 1
    step(1, 16'hC100, 8'h99, 8'h01, 0, 1, "R2 add 99+01");
    // R8: idle cycles with changed operands hold outputs
    step(0, 16'hC100, 8'h12, 8'h34, 1, 0, "R8 hold");
    step(0, 16'h8100, 8'h55, 8'h66, 0, 1, "R8 hold");
    // R9: unmatched words
    step(1, 16'hFFFF, 8'h11, 8'h22, 0, 0, "R9 bad op");
    step(1, 16'hC110, 8'h11, 8'h22, 0, 0, "R9 add with bit4 set");
    step(1, 16'h4840, 8'h11, 8'h22, 0, 0, "R9 neg pattern broken");
    // R1: free fields do not change the operation
    step(1, 16'hCF0F, 8'h45, 8'h38, 1, 1, "R1 add free bits");
    step(1, 16'h8F0F, 8'h45, 8'h38, 1, 1, "R1 sub free bits");
    step(1, 16'h483F, 8'hAA, 8'h38, 0, 1, "R1 neg free bits");
    // R3: non-BCD outputs, R4 negate of zero
    step(1, 16'h8100, 8'h00, 8'h0F, 0, 1, "R3 sub non-bcd");
    step(1, 16'h4800, 8'h77, 8'h00, 0, 1, "R4 neg zero");
    step(1, 16'h4800, 8'h77, 8'h00, 1, 1, "R4 neg zero with x");

    for (int i = 0; i < 65536; i++) begin
      int xz;
      xz = (i ^ (i >> 8) ^ (i >> 2)) & 3;
      step(1, 16'hC100 | 16'((i % 8) << 9) | 16'((i >> 3) % 16),
           i >> 8, i % 256, xz[1], xz[0], "R2 add sweep");
    end
    for (int i = 0; i < 65536; i++) begin
      int xz;
      xz = (i ^ (i >> 8) ^ (i >> 2)) & 3;
      step(1, 16'h8100 | 16'((i % 8) << 9) | 16'((i >> 3) % 16),
           i >> 8, i % 256, xz[1], xz[0], "R3 sub sweep");
    end
    for (int j = 0; j < 1024; j++) begin
      step(1, 16'h4800 | 16'(j % 64), (j * 37) % 256, j % 256,
           j[9], j[8], "R4 neg sweep (dst ignored)");
    end

    in_valid = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule